// File: doc/BRIEF.md
# Partial-Word Store Byte Steering

This block converts a partial-word store request into a single memory write beat. A request carries a byte address, a register value and a form select. The begin form writes the bytes from the addressed byte up to the end of its aligned word. The end form writes the bytes of that word that lie below the addressed byte. The low address bits choose the byte range, and the two forms always cover complementary ranges.

The output is one registered beat. It carries the aligned word address, a big-endian byte-enable mask, the write data with disabled lanes forced to zero, and a probe flag. The probe flag marks an end-form request at an aligned address: such a request writes no bytes, but it still needs a zero-length write access. Every write goes out as one beat, including the three-byte cases, so a store is never split into a byte write and a halfword write.

Top module: `sbs_store_steer`

## Requirements
- R1: `valid_o` is high for exactly one cycle, in the cycle after each cycle in which `req_i` is sampled high, and it is low otherwise.
- R2: `waddr_o` equals the request address with its two low bits cleared.
- R3: Begin form (`end_sel_i`=0) enables the bytes at offsets from the address offset up to 3. Enable bit 3 is offset 0. For offsets 0, 1, 2 and 3 the masks are 4'b1111, 4'b0111, 4'b0011 and 4'b0001.
- R4: End form (`end_sel_i`=1) enables the bytes at offsets below the address offset. For offsets 0, 1, 2 and 3 the masks are 4'b0000, 4'b1000, 4'b1100 and 4'b1110.
- R5: Each enabled lane carries the value bits at the same position, unshifted. Enable bit k maps to `wdata_o[8k+7:8k]`, so bit 3 carries bits 31:24. A three-byte store is issued as a single beat.
- R6: `probe_o` is high with the beat exactly when the request was end form at offset 0, and the mask is then all zero. The begin form never raises `probe_o`.
- R7: Lanes whose enable bit is 0 carry zero in `wdata_o`.
- R8: During reset and while idle, `valid_o`, `probe_o` and `be_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, one request per cycle |
| end_sel_i | input | 1 | 0 = begin form, 1 = end form |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Register value to store |
| valid_o | output | 1 | Write beat valid, one cycle per request |
| waddr_o | output | ADDR_W | Aligned word address |
| be_o | output | DATA_W/8 | Byte enables, bit 3 = lowest-addressed byte |
| wdata_o | output | DATA_W | Lane-aligned write data |
| probe_o | output | 1 | Zero-byte write probe |

## Verification
Two things can meet in one cycle: the beat of one request is presented on the outputs while the next request is captured. The case that matters most is a zero-byte probe directly next to a full write. The bench provokes this with an unbroken stream of requests that alternates between forms and offsets, including a probe followed at once by a begin-form full-word write. At every cycle it checks that the mask, data, address and probe flag belong only to the preceding request, with no enables or data carried over from the one before.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    FORM_BEGIN = 1'b0,
    FORM_END   = 1'b1
  } form_e;
endpackage

// File: rtl/sbs_lane_mask.sv
module sbs_lane_mask
  import sbs_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int OFF_W  = 2
) (
  input  form_e             form_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [NBYTES-1:0] be_o,
  output logic              probe_o
);
  // Lane j (offset from word start) maps to enable bit NBYTES-1-j.
  for (genvar j = 0; j < NBYTES; j++) begin : g_lane
    localparam logic [OFF_W-1:0] LaneOff = OFF_W'(j);
    assign be_o[NBYTES-1-j] = (form_i == FORM_BEGIN) ? (LaneOff >= off_i)
                                                     : (LaneOff <  off_i);
  end

  assign probe_o = (form_i == FORM_END) && (off_i == '0);
endmodule

// File: rtl/sbs_lane_data.sv
module sbs_lane_data #(
  parameter int NBYTES = 4,
  localparam int DataW = NBYTES * 8
) (
  input  logic [NBYTES-1:0] be_i,
  input  logic [DataW-1:0]  val_i,
  output logic [DataW-1:0]  wdata_o
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign wdata_o[8*k +: 8] = be_i[k] ? val_i[8*k +: 8] : 8'h00;
  end
endmodule

// File: rtl/sbs_out_reg.sv
module sbs_out_reg #(
  parameter int ADDR_W = 32,
  parameter int NBYTES = 4,
  localparam int DataW = NBYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [NBYTES-1:0] be_i,
  input  logic [DataW-1:0]  wdata_i,
  input  logic              probe_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [NBYTES-1:0] be_o,
  output logic [DataW-1:0]  wdata_o,
  output logic              probe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      be_o    <= '0;
      probe_o <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      valid_o <= req_i;
      be_o    <= req_i ? be_i : '0;
      probe_o <= req_i & probe_i;
      if (req_i) begin
        waddr_o <= waddr_i;
        wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/sbs_store_steer.sv
module sbs_store_steer
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              end_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [NBYTES-1:0] be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              probe_o
);
  form_e             form;
  logic [NBYTES-1:0] be_d;
  logic [DATA_W-1:0] wdata_d;
  logic              probe_d;
  logic [ADDR_W-1:0] waddr_d;

  assign form    = form_e'(end_sel_i);
  assign waddr_d = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  sbs_lane_mask #(.NBYTES(NBYTES), .OFF_W(OFF_W)) u_mask (
    .form_i  (form),
    .off_i   (addr_i[OFF_W-1:0]),
    .be_o    (be_d),
    .probe_o (probe_d)
  );

  sbs_lane_data #(.NBYTES(NBYTES)) u_data (
    .be_i    (be_d),
    .val_i   (data_i),
    .wdata_o (wdata_d)
  );

  sbs_out_reg #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .waddr_i (waddr_d),
    .be_i    (be_d),
    .wdata_i (wdata_d),
    .probe_i (probe_d),
    .valid_o (valid_o),
    .waddr_o (waddr_o),
    .be_o    (be_o),
    .wdata_o (wdata_o),
    .probe_o (probe_o)
  );
endmodule

// File: rtl/sbs_store_steer_chk.sv
module sbs_store_steer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              end_sel_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] waddr_o,
  input logic [NBYTES-1:0] be_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              probe_o
);
  logic [DATA_W-1:0] off_lanes;
  always_comb begin
    for (int k = 0; k < NBYTES; k++) off_lanes[8*k +: 8] = {8{~be_o[k]}};
  end

  a_r1_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(req_i));

  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (waddr_o[OFF_W-1:0] == '0) &&
                (waddr_o[ADDR_W-1:OFF_W] == $past(addr_i[ADDR_W-1:OFF_W])));

  a_r3_begin_hits_last_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(end_sel_i)) |-> be_o[0] && !probe_o);

  a_r4_end_hits_first_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(end_sel_i) && !probe_o) |-> be_o[NBYTES-1]);

  a_r6_probe_writes_nothing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_o |-> valid_o && (be_o == '0));

  a_r7_idle_lanes_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((wdata_o & off_lanes) == '0));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (be_o == '0) && !probe_o);
endmodule

bind sbs_store_steer sbs_store_steer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sbs_store_steer.sv
`timescale 1ns/1ps
module tb_sbs_store_steer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        end_sel_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] data_i = '0;
  logic        valid_o;
  logic [31:0] waddr_o;
  logic [3:0]  be_o;
  logic [31:0] wdata_o;
  logic        probe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sbs_store_steer dut (.*);

  function automatic logic [3:0] exp_be(input logic e, input logic [1:0] off);
    logic [3:0] b;
    b = 4'b1111 >> off;
    return e ? ~b : b;
  endfunction

  function automatic logic [31:0] exp_data(input logic [3:0] be, input logic [31:0] v);
    return v & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_beat(input logic e, input logic [31:0] a, input logic [31:0] v);
    logic [3:0] b;
    b = exp_be(e, a[1:0]);
    chk("R1 valid", {31'b0, valid_o}, 32'd1);
    chk("R2 waddr", waddr_o, {a[31:2], 2'b00});
    chk(e ? "R4 end mask" : "R3 begin mask", {28'b0, be_o}, {28'b0, b});
    chk("R5/R7 wdata", wdata_o, exp_data(b, v));
    chk("R6 probe", {31'b0, probe_o}, {31'b0, e && a[1:0] == 2'b00});
  endtask

  task automatic issue(input logic e, input logic [31:0] a, input logic [31:0] v);
    @(negedge clk_i);
    req_i = 1'b1; end_sel_i = e; addr_i = a; data_i = v;
    @(negedge clk_i);
    req_i = 1'b0;
    chk_beat(e, a, v);
    @(negedge clk_i);
    chk("R1 single pulse", {31'b0, valid_o}, 32'd0);
    chk("R8 idle mask", {28'b0, be_o}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R8 reset valid", {31'b0, valid_o}, 32'd0);
    chk("R8 reset be", {28'b0, be_o}, 32'd0);
    chk("R8 reset probe", {31'b0, probe_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle after reset", {31'b0, valid_o}, 32'd0);
  endtask

  task automatic t_begin_form();
    for (int o = 0; o < 4; o++) issue(1'b0, 32'h1000_2000 + o, 32'hA1B2_C3D4);
    issue(1'b0, 32'hFFFF_FFFD, 32'h0012_3456); // R5 three-byte begin, single beat
  endtask

  task automatic t_end_form();
    for (int o = 0; o < 4; o++) issue(1'b1, 32'h8765_4320 + o, 32'h5E6F_7081);
    issue(1'b1, 32'h0000_0007, 32'hCAFE_BEEF); // R5 three-byte end, single beat
    issue(1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFF); // R6 probe, data ignored
  endtask

  task automatic t_stream();
    logic        es[8];
    logic [31:0] as[8];
    logic [31:0] vs[8];
    es = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    as = '{32'h40, 32'h44, 32'h4B, 32'h4D, 32'h50, 32'h62, 32'h73, 32'h80};
    vs = '{32'h1111_1111, 32'hDEAD_BEEF, 32'h0102_0304, 32'hF0E1_D2C3,
           32'h89AB_CDEF, 32'h7777_0000, 32'h55AA_55AA, 32'h0F0F_F0F0};
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk_i);
      if (i > 0) chk_beat(es[i-1], as[i-1], vs[i-1]);
      if (i < 8) begin
        req_i = 1'b1; end_sel_i = es[i]; addr_i = as[i]; data_i = vs[i];
      end else req_i = 1'b0;
    end
    @(negedge clk_i);
    chk("R1 stream end", {31'b0, valid_o}, 32'd0);
  endtask

  task automatic t_idle_inputs();
    @(negedge clk_i);
    end_sel_i = 1'b1; addr_i = 32'h0; data_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    chk("R8 idle no probe", {31'b0, probe_o}, 32'd0);
    chk("R1 idle no valid", {31'b0, valid_o}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_begin_form();
    t_end_form();
    t_stream();
    t_idle_inputs();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule